// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers interrupt requests from a set of numbered sources and lets software give every source one of three priority levels, or switch it off. Every clock cycle it picks the single most urgent pending request and compares that request's level with the level the core is already servicing. When the new request is more urgent, the block raises a request line to the core and drives the winning level and a 21-bit vector address alongside it. The address normally comes from a vector table at a programmable base. Two fast channels can replace that table address with a 21-bit address held in registers, for one chosen vector number each.

Requests are latched as pending bits, and software can read them back. A pending bit is cleared when the core acknowledges the request on show. A source that still holds its request line high after the acknowledge becomes pending again. Software reaches the block through a plain 16-bit word register bus, which has a combinational read path and writes on the clock edge.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Each source has a 2-bit field. 00 disables the source and is the reset value; 01, 10 and 11 select levels 0, 1 and 2, which appear on `lvl_o` as 0, 1 and 2. A disabled source never becomes pending, and disabling a pending source clears its pending bit. Source i sits in word i/8 at bits [2*(i%8)+1 : 2*(i%8)]. Words 0 and 1 hold the fields.
- R2: The winner is the pending enabled source with the highest level. Among sources at that level, the lowest vector number wins.
- R3: `irq_o` is raised only when the winner's level plus one is greater than `core_mask_i`. Mask 0 means nothing is in service; mask k means level k-1 is in service, so mask 3 blocks every request.
- R4: The vector number of source i is VEC_FIRST+i (VEC_FIRST defaults to 16). The table address is {base[12:0], 8'h00} + 2*vector number. The base is held in bits [12:0] of word 2.
- R5: Fast channel c (c = 0 or 1) uses three words. Word 3+3c holds a 7-bit vector number in bits [6:0]. Word 4+3c holds address bits [15:0]. Word 5+3c holds address bits [20:16] in its bits [4:0]. When the winner's vector number matches a channel, that channel's address replaces the table address. Channel 0 takes precedence when both channels match.
- R6: A one-cycle request pulse on an enabled source is held as pending until it is acknowledged. Word 9 bit i reads the pending state of source i.
- R7: `ack_i` sampled high while `irq_o` is high clears the presented source's pending bit. On the next cycle `irq_o` is low and `lvl_o` and `vec_addr_o` are unchanged. A source whose request stays high is presented again afterwards.
- R8: Bit 15 of word 10 reads the current state of `irq_o`. Every other bit of word 10 reads 0.
- R9: Unimplemented bits read 0. Writes to them, to word 9 and to word 10 have no effect.
- R10: A request sampled at one clock edge becomes pending there and reaches `irq_o` at the following edge. A register or mask change reaches the outputs one edge after it is taken in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register word address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from the address |
| req_i | input | N_SRC | Request inputs; bit i is source i |
| core_mask_i | input | 2 | Level the core is servicing (0 = none) |
| ack_i | input | 1 | Core acknowledges the presented request |
| irq_o | output | 1 | Interrupt request to the core |
| lvl_o | output | 2 | Level of the presented request |
| vec_addr_o | output | 21 | Vector address of the presented request |

## Verification
The bench aims at four kinds of corner case:
- **Ties within a level.** A wrong tie-break would show up as the wrong vector address or the wrong drain order.
- **Mask boundary.** The bench checks exactly where the mask begins to block a level. An off-by-one comparison would raise `irq_o` for a request of equal level, or stay silent for a more urgent one.
- **Fast channels.** It checks both channels matching the same vector and the no-match fallback. A wrong precedence or a stale match would return the other channel's address, or a table address where a fast one is due.
- **Acknowledge timing.** It holds a level request high through an acknowledge and disables a source while it is pending. A design that failed to drop `irq_o`, changed the outputs during the acknowledge, lost a pending bit, or kept one for a disabled source would fail the pending readback or the output checks.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int DW    = 16;
  localparam int VN_W  = 7;
  localparam int VA_W  = 21;
  localparam int VB_W  = VA_W - 8;
  localparam int LVL_W = 2;

  typedef enum logic [1:0] {
    FLD_OFF = 2'b00,
    FLD_L0  = 2'b01,
    FLD_L1  = 2'b10,
    FLD_L2  = 2'b11
  } prio_fld_e;

  typedef struct packed {
    logic [VN_W-1:0] vnum;
    logic [VA_W-1:0] addr;
  } fast_ch_t;
endpackage

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int N_SRC  = 16,
  parameter int N_FAST = 2,
  parameter int AW     = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [DW-1:0]           rdata_o,
  input  logic [N_SRC-1:0]        pend_i,
  input  logic                    irq_i,
  output logic [N_SRC-1:0][1:0]   rank_o,
  output logic [VB_W-1:0]         vbase_o,
  output fast_ch_t [N_FAST-1:0]   fast_o
);
  localparam int PR_REGS = (N_SRC + 7) / 8;
  localparam int PD_REGS = (N_SRC + 15) / 16;
  localparam int A_VBASE = PR_REGS;
  localparam int A_FAST  = PR_REGS + 1;
  localparam int A_PEND  = A_FAST + 3 * N_FAST;
  localparam int A_CTRL  = A_PEND + PD_REGS;

  logic [N_SRC-1:0][1:0]     prio_q;
  logic [VB_W-1:0]           vbase_q;
  logic [PD_REGS*DW-1:0]     pend_pad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q  <= '0;
      vbase_q <= '0;
    end else if (we_i) begin
      for (int i = 0; i < N_SRC; i++)
        if (addr_i == AW'(i / 8)) prio_q[i] <= wdata_i[2*(i%8) +: 2];
      if (addr_i == AW'(A_VBASE)) vbase_q <= wdata_i[VB_W-1:0];
    end
  end

  for (genvar c = 0; c < N_FAST; c++) begin : g_fast
    logic [VN_W-1:0]    fm_q;
    logic [DW-1:0]      fl_q;
    logic [VA_W-DW-1:0] fh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fm_q <= '0;
        fl_q <= '0;
        fh_q <= '0;
      end else if (we_i) begin
        if (addr_i == AW'(A_FAST + 3*c))     fm_q <= wdata_i[VN_W-1:0];
        if (addr_i == AW'(A_FAST + 3*c + 1)) fl_q <= wdata_i;
        if (addr_i == AW'(A_FAST + 3*c + 2)) fh_q <= wdata_i[VA_W-DW-1:0];
      end
    end
    assign fast_o[c].vnum = fm_q;
    assign fast_o[c].addr = {fh_q, fl_q};
  end

  always_comb begin
    pend_pad = '0;
    pend_pad[N_SRC-1:0] = pend_i;
  end

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < PR_REGS; r++)
      if (addr_i == AW'(r))
        for (int j = 0; j < 8; j++)
          if (r*8 + j < N_SRC) rdata_o[2*j +: 2] = prio_q[r*8 + j];
    if (addr_i == AW'(A_VBASE)) rdata_o[VB_W-1:0] = vbase_q;
    for (int c = 0; c < N_FAST; c++) begin
      if (addr_i == AW'(A_FAST + 3*c))     rdata_o[VN_W-1:0] = fast_o[c].vnum;
      if (addr_i == AW'(A_FAST + 3*c + 1)) rdata_o = fast_o[c].addr[DW-1:0];
      if (addr_i == AW'(A_FAST + 3*c + 2)) rdata_o[VA_W-DW-1:0] = fast_o[c].addr[VA_W-1:DW];
    end
    for (int p = 0; p < PD_REGS; p++)
      if (addr_i == AW'(A_PEND + p)) rdata_o = pend_pad[p*DW +: DW];
    if (addr_i == AW'(A_CTRL)) rdata_o[DW-1] = irq_i;
  end

  assign rank_o  = prio_q;
  assign vbase_o = vbase_q;
endmodule

// File: rtl/pic_pend.sv
module pic_pend #(
  parameter int N_SRC = 16,
  localparam int IW   = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic             clr_i,
  input  logic [IW-1:0]    win_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else
      for (int i = 0; i < N_SRC; i++)
        pend_q[i] <= en_i[i] & ~(clr_i && win_i == IW'(i)) & (pend_q[i] | req_i[i]);
  end

  assign pend_o = pend_q;

  AST_ACK_CLEARS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !pend_q[$past(win_i)]); // R7
endmodule

// File: rtl/pic_arb.sv
module pic_arb
  import pic_pkg::*;
#(
  parameter int N_SRC     = 16,
  parameter int N_FAST    = 2,
  parameter int VEC_FIRST = 16,
  localparam int IW       = $clog2(N_SRC)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_SRC-1:0]      pend_i,
  input  logic [N_SRC-1:0][1:0] rank_i,
  input  logic [1:0]            core_mask_i,
  input  logic [VB_W-1:0]       vbase_i,
  input  fast_ch_t [N_FAST-1:0] fast_i,
  input  logic                  ack_i,
  output logic                  irq_o,
  output logic [LVL_W-1:0]      lvl_o,
  output logic [VA_W-1:0]       vaddr_o,
  output logic [IW-1:0]         win_o
);
  logic [1:0]      best_rank;
  logic [IW-1:0]   best_idx;
  logic [VN_W-1:0] vnum;
  logic [VA_W-1:0] va_d;
  logic            go;

  // descending scan with >= leaves the lowest index of the top level
  always_comb begin
    best_rank = '0;
    best_idx  = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (pend_i[i] && rank_i[i] != 2'd0 && rank_i[i] >= best_rank) begin
        best_rank = rank_i[i];
        best_idx  = IW'(i);
      end
  end

  assign go   = best_rank > core_mask_i;
  assign vnum = VN_W'(VEC_FIRST) + VN_W'(best_idx);

  always_comb begin
    va_d = VA_W'({vbase_i, 8'h00}) + VA_W'({vnum, 1'b0});
    for (int c = N_FAST - 1; c >= 0; c--)
      if (fast_i[c].vnum == vnum) va_d = fast_i[c].addr;
  end

  logic                 irq_q;
  logic [LVL_W-1:0]     lvl_q;
  logic [VA_W-1:0]      va_q;
  logic [IW-1:0]        win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      lvl_q <= '0;
      va_q  <= '0;
      win_q <= '0;
    end else if (ack_i && irq_q) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= go;
      if (go) begin
        lvl_q <= best_rank - 2'd1;
        va_q  <= va_d;
        win_q <= best_idx;
      end
    end
  end

  assign irq_o   = irq_q;
  assign lvl_o   = lvl_q;
  assign vaddr_o = va_q;
  assign win_o   = win_q;

  AST_ACK_DROPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_q) |=> !irq_q); // R7
  AST_ACK_HOLDS_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_q) |=> ($stable(va_q) && $stable(lvl_q))); // R7
  AST_MASK_RESPECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> ({1'b0, lvl_q} + 3'd1 > {1'b0, $past(core_mask_i)})); // R3
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int N_SRC     = 16,
  parameter int N_FAST    = 2,
  parameter int VEC_FIRST = 16,
  parameter int AW        = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [15:0]      reg_wdata_i,
  output logic [15:0]      reg_rdata_o,
  input  logic [N_SRC-1:0] req_i,
  input  logic [1:0]       core_mask_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic [1:0]       lvl_o,
  output logic [20:0]      vec_addr_o
);
  localparam int IW = $clog2(N_SRC);

  logic [N_SRC-1:0][1:0]   rank;
  logic [N_SRC-1:0]        en;
  logic [N_SRC-1:0]        pend;
  logic [VB_W-1:0]         vbase;
  fast_ch_t [N_FAST-1:0]   fast;
  logic [IW-1:0]           win;

  for (genvar g = 0; g < N_SRC; g++) begin : g_en
    assign en[g] = |rank[g];
  end

  pic_regs #(.N_SRC(N_SRC), .N_FAST(N_FAST), .AW(AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .pend_i  (pend),
    .irq_i   (irq_o),
    .rank_o  (rank),
    .vbase_o (vbase),
    .fast_o  (fast)
  );

  pic_pend #(.N_SRC(N_SRC)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .en_i   (en),
    .clr_i  (ack_i & irq_o),
    .win_i  (win),
    .pend_o (pend)
  );

  pic_arb #(.N_SRC(N_SRC), .N_FAST(N_FAST), .VEC_FIRST(VEC_FIRST)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pend_i      (pend),
    .rank_i      (rank),
    .core_mask_i (core_mask_i),
    .vbase_i     (vbase),
    .fast_i      (fast),
    .ack_i       (ack_i),
    .irq_o       (irq_o),
    .lvl_o       (lvl_o),
    .vaddr_o     (vec_addr_o),
    .win_o       (win)
  );
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int A_VB = 2, A_PD = 9, A_CT = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        we = 0;
  logic [4:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic [15:0] req = 0;
  logic [1:0]  core_mask = 0;
  logic        ack = 0;
  logic        irq_o;
  logic [1:0]  lvl_o;
  logic [20:0] vec_addr_o;

  int nchk = 0, nfail = 0;
  logic [1:0]  fld [16];
  logic [15:0] pm = 0;
  int          fm [2];
  logic [20:0] fa [2];
  logic [12:0] vb = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .req_i(req),
    .core_mask_i(core_mask), .ack_i(ack), .irq_o(irq_o), .lvl_o(lvl_o),
    .vec_addr_o(vec_addr_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int win_idx();
    int best = -1;
    logic [1:0] bl = 0;
    for (int i = 0; i < 16; i++)
      if (pm[i] && fld[i] != 0 && fld[i] > bl) begin best = i; bl = fld[i]; end
    return best;
  endfunction

  function automatic logic [20:0] exp_addr(input int i);
    int vn = 16 + i;
    if (fm[0] == vn) return fa[0];
    if (fm[1] == vn) return fa[1];
    return {vb, 8'h00} + 21'(2 * vn);
  endfunction

  function automatic logic [15:0] fword(input int r);
    logic [15:0] w = 0;
    for (int j = 0; j < 8; j++) w[2*j +: 2] = fld[r*8 + j];
    return w;
  endfunction

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk); we = 1; addr = 5'(a); wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk); addr = 5'(a); #1 d = rdata;
  endtask

  task automatic write_flds();
    wr(0, fword(0)); wr(1, fword(1));
    for (int i = 0; i < 16; i++) if (fld[i] == 0) pm[i] = 0;
  endtask

  task automatic set_fast(input int c, input int vn, input logic [20:0] a);
    fm[c] = vn; fa[c] = a;
    wr(3 + 3*c, 16'(vn)); wr(4 + 3*c, a[15:0]); wr(5 + 3*c, {11'b0, a[20:16]});
  endtask

  task automatic pulse(input logic [15:0] p);
    @(negedge clk); req = p;
    @(negedge clk); req = 0;
    for (int i = 0; i < 16; i++) if (p[i] && fld[i] != 0) pm[i] = 1;
  endtask

  task automatic drain(input string tg);
    int w;
    logic [20:0] a0;
    logic [1:0] l0;
    w = win_idx();
    while (w >= 0) begin
      chk({tg, " R2 irq"}, 32'(irq_o), 1);
      chk({tg, " R2/R1 lvl"}, 32'(lvl_o), 32'(fld[w]) - 1);
      chk({tg, " R4_R5 addr"}, 32'(vec_addr_o), 32'(exp_addr(w)));
      a0 = vec_addr_o; l0 = lvl_o;
      @(negedge clk); ack = 1;
      @(negedge clk); ack = 0; pm[w] = 0;
      chk({tg, " R7 drop"}, 32'(irq_o), 0);
      chk({tg, " R7 hold"}, {9'b0, lvl_o, vec_addr_o}, {9'b0, l0, a0});
      @(negedge clk);
      w = win_idx();
    end
    chk({tg, " R7 empty"}, 32'(irq_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) fld[i] = 0;
    fm[0] = 0; fm[1] = 0; fa[0] = 0; fa[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    chk("R1 reset irq", 32'(irq_o), 0);
    rd(0, d); chk("R1 reset fields", 32'(d), 0);
    rd(A_PD, d); chk("R6 reset pend", 32'(d), 0);
    rd(A_CT, d); chk("R8 reset ctrl", 32'(d), 0);

    // all disabled: requests ignored
    pulse(16'hFFFF);
    repeat (3) @(negedge clk);
    chk("R1 disabled irq", 32'(irq_o), 0);
    rd(A_PD, d); chk("R1 disabled pend", 32'(d), 0);

    // level encoding readback
    fld[3] = 2'b01; fld[10] = 2'b11; write_flds();
    rd(0, d); chk("R1 field word0", 32'(d), 32'(fword(0)));
    rd(1, d); chk("R1 field word1", 32'(d), 32'(fword(1)));

    // timing of a single pulse
    pulse(16'h0008);
    chk("R10 not yet", 32'(irq_o), 0);
    @(negedge clk);
    chk("R10 one edge later", 32'(irq_o), 1);
    drain("single");

    // tie within a level, plus a higher level
    fld[2] = 2'b10; fld[7] = 2'b10; fld[12] = 2'b10; fld[10] = 2'b01; write_flds();
    pulse(16'h1484);
    @(negedge clk);
    drain("tie");

    // mask boundary: level 1 request
    for (int i = 0; i < 16; i++) fld[i] = 0;
    fld[2] = 2'b10; write_flds();
    core_mask = 2'd2;
    pulse(16'h0004);
    repeat (3) @(negedge clk);
    chk("R3 equal level blocked", 32'(irq_o), 0);
    rd(A_PD, d); chk("R6 pend held", 32'(d), 32'h0004);
    rd(A_CT, d); chk("R8 ctrl low", 32'(d), 0);
    core_mask = 2'd1;
    repeat (2) @(negedge clk);
    chk("R3 higher level passes", 32'(irq_o), 1);
    rd(A_CT, d); chk("R8 ctrl high", 32'(d), 32'h8000);
    core_mask = 2'd3;
    repeat (2) @(negedge clk);
    chk("R3 mask 3 blocks", 32'(irq_o), 0);
    core_mask = 2'd0;
    repeat (2) @(negedge clk);
    drain("mask");

    // disabling a pending source drops it
    fld[4] = 2'b11; write_flds();
    core_mask = 2'd3;
    pulse(16'h0010);
    @(negedge clk);
    rd(A_PD, d); chk("R6 pend set", 32'(d), 32'h0010);
    fld[4] = 2'b00; write_flds();
    @(negedge clk);
    rd(A_PD, d); chk("R1 disable clears pend", 32'(d), 0);
    core_mask = 2'd0;
    repeat (2) @(negedge clk);
    chk("R1 disabled no irq", 32'(irq_o), 0);

    // fast channels
    vb = 13'h0ABC; wr(A_VB, 16'(vb));
    fld[5] = 2'b01; write_flds();
    set_fast(0, 21, 21'h1ABCD5);
    set_fast(1, 21, 21'h0F0F0F);
    pulse(16'h0020); @(negedge clk);
    chk("R5 ch0 precedence", 32'(vec_addr_o), 32'h1ABCD5);
    drain("fast0");
    set_fast(0, 0, 21'h1ABCD5);
    pulse(16'h0020); @(negedge clk);
    chk("R5 ch1 match", 32'(vec_addr_o), 32'h0F0F0F);
    drain("fast1");
    set_fast(1, 0, 21'h0F0F0F);
    pulse(16'h0020); @(negedge clk);
    chk("R4 table addr", 32'(vec_addr_o), 32'({13'h0ABC, 8'h00} + 21'd42));
    drain("table");

    // level request held across acknowledge
    fld[9] = 2'b01; write_flds();
    @(negedge clk); req = 16'h0200;
    repeat (3) @(negedge clk);
    chk("R7 level present", 32'(irq_o), 1);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    chk("R7 level drop", 32'(irq_o), 0);
    repeat (2) @(negedge clk);
    chk("R7 level reassert", 32'(irq_o), 1);
    chk("R7 reassert addr", 32'(vec_addr_o), 32'(exp_addr(9)));
    @(negedge clk); ack = 1; req = 0;
    @(negedge clk); ack = 0;
    repeat (2) @(negedge clk);
    chk("R7 level cleared", 32'(irq_o), 0);
    pm = 0;

    // reserved bits and read-only words
    wr(5, 16'hFFFF); rd(5, d); chk("R9 fast high", 32'(d), 32'h001F);
    fa[0][20:16] = 5'h1F;
    wr(3, 16'hFFFF); rd(3, d); chk("R9 fast vnum", 32'(d), 32'h007F);
    fm[0] = 127;
    wr(A_VB, 16'hFFFF); rd(A_VB, d); chk("R9 base", 32'(d), 32'h1FFF);
    vb = 13'h1FFF;
    wr(A_PD, 16'hFFFF); rd(A_PD, d); chk("R9 pend ro", 32'(d), 0);
    wr(A_CT, 16'hFFFF); rd(A_CT, d); chk("R9 ctrl ro", 32'(d), 0);

    // constrained random
    for (int it = 0; it < 24; it++) begin
      for (int i = 0; i < 16; i++) fld[i] = 2'($urandom_range(0, 3));
      write_flds();
      for (int c = 0; c < 2; c++)
        set_fast(c, ($urandom_range(0, 1) == 1) ? 16 + $urandom_range(0, 15) : 0,
                 21'($urandom));
      vb = 13'($urandom); wr(A_VB, 16'(vb));
      pulse(16'($urandom));
      @(negedge clk);
      rd(A_PD, d); chk("R6 random pend", 32'(d), 32'(pm));
      drain("rand");
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule